// File: doc/BRIEF.md
# DTMF Steering Guard and Serial Digit Readout

This block sits behind a tone-pair detector. The detector supplies a logic-level flag that says whether a valid tone pair is present, and a 4-bit code that names the digit. The block passes the raw flag straight out as an early steering indication. It also produces a guarded steering output that changes state only after the raw flag has held its new level for a set time. A separate time applies for each direction, so short bursts are rejected and short dropouts inside one digit are bridged.

When the guarded output rises, the block captures the digit code. A host reads the captured code over a single data line. It applies four rising edges on a shift clock and gets the least significant bit first. The capture happens only at a guarded rise, so a new digit cannot corrupt a readout that is already in progress.

The guard times are counted in millisecond ticks. The tick is divided from the block clock, and the default divisor suits a clock of about 3.58 MHz. Any change of the raw flag during a guard interval restarts both the tick divider and the tick count.

Top module: `dtmf_guard_reader`

## Requirements
- R1: `early_steer` equals `tone_raw` in the same cycle, with no register in between.
- R2: When `steer` is low and `tone_raw` has been sampled high on PRESENT_MS*TICK_DIV consecutive rising clock edges, `steer` goes high at the last of those edges.
- R3: A high run of `tone_raw` that is shorter than PRESENT_MS*TICK_DIV edges leaves `steer` low. The next high run starts counting again from zero.
- R4: When `steer` is high and `tone_raw` has been sampled low on ABSENT_MS*TICK_DIV consecutive edges, `steer` goes low at the last of those edges.
- R5: A low gap in `tone_raw` that is shorter than ABSENT_MS*TICK_DIV edges leaves `steer` high, so a split tone counts as one digit.
- R6: `code_in` is captured only at the edge where `steer` rises. Changes to `code_in` at any other time do not alter the value that is read out.
- R7: A shift clock rising edge is a cycle where `rd_clk` is 1 and was 0 at the previous edge. The first such edge of a group of four loads the captured code, and `dout` then shows bit 0. The second, third and fourth edges show bits 1, 2 and 3. A fifth edge starts a new group and loads the code again.
- R8: All 16 values of the 4-bit code are captured and read out intact.
- R9: During reset, `steer` is 0, `dout` is 0, and the next shift clock edge is treated as the first of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the tick divisor is counted in these cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_raw | input | 1 | Tone-pair-present flag from the detector |
| code_in | input | CODE_W | Digit code from the detector |
| rd_clk | input | 1 | Host shift clock, sampled by clk |
| early_steer | output | 1 | Unguarded copy of tone_raw |
| steer | output | 1 | Guarded steering flag |
| dout | output | 1 | Serial digit data, LSB first |

## Verification
The bench drives tone runs exactly one edge shorter than each guard and exactly equal to it. A timer that is off by one tick or one cycle flips `steer` early or late, and the bench sees this at the exact edge. Gaps just under the absent guard check that a design which does not restart its timer, or which shares one count across both directions, does not report two digits. Readouts follow code changes made mid-tone, so a latch that follows `code_in` or reloads on the wrong edge shifts out the wrong bits. Running readouts back to back catches a bit counter that fails to wrap after four edges.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;

  // Total clock edges of continuous mismatch needed to flip the steering flag.
  function automatic int guard_cycles(input int ms, input int div);
    return ms * div;
  endfunction

  // True when one more completed tick reaches the guard limit.
  function automatic logic limit_hit(input int ticks_done, input int limit_ms);
    return (ticks_done + 1) >= limit_ms;
  endfunction

  // Next readout bit position, wrapping after the last bit of the code.
  function automatic int next_bit(input int idx, input int width);
    return (idx == width - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/dtmf_tick_gen.sv
module dtmf_tick_gen #(
  parameter int DIV   = 3580,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic             tick,
  output logic [CNT_W-1:0] ticks
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre;

  assign tick = (pre == PRE_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre   <= '0;
      ticks <= '0;
    end else if (tick) begin
      pre   <= '0;
      ticks <= ticks + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  AST_TICKS_ADVANCE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(ticks)); // R2
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int TICK_DIV   = 3580,
  parameter int PRESENT_MS = 30,
  parameter int ABSENT_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone,
  output logic steer,
  output logic steer_rise
);
  localparam int MAX_MS = (PRESENT_MS > ABSENT_MS) ? PRESENT_MS : ABSENT_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  logic            mismatch;
  logic            tick;
  logic [MS_W-1:0] ticks;
  logic            hit;
  logic            clear;
  int              limit_ms;

  assign mismatch   = tone ^ steer;
  assign limit_ms   = steer ? ABSENT_MS : PRESENT_MS;
  assign hit        = mismatch && tick && dtmf_guard_pkg::limit_hit(int'(ticks), limit_ms);
  assign clear      = !mismatch || hit;
  assign steer_rise = hit && !steer;

  dtmf_tick_gen #(.DIV(TICK_DIV), .CNT_W(MS_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (tick),
    .ticks (ticks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   steer <= 1'b0;
    else if (hit) steer <= ~steer;
  end

  AST_FLIP_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (steer != $past(steer)) |-> ($past(tone) == steer)); // R2
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch) |=> (ticks == '0)); // R3
  AST_ABSENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (steer && tone) |=> steer); // R5
endmodule

// File: rtl/dtmf_readout.sv
module dtmf_readout #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic              rd_clk,
  output logic              dout
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic [CODE_W-1:0] code_lat;
  logic [CODE_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;
  logic              rd_prev;
  logic              rd_rise;

  assign rd_rise = rd_clk && !rd_prev;
  assign dout    = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_lat <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      rd_prev  <= 1'b0;
    end else begin
      rd_prev <= rd_clk;
      if (capture) code_lat <= code_in;
      if (rd_rise) begin
        shreg   <= (bit_idx == '0) ? code_lat : (shreg >> 1);
        bit_idx <= IDX_W'(dtmf_guard_pkg::next_bit(int'(bit_idx), CODE_W));
      end
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(code_lat)); // R6
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(shreg)); // R7
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> (bit_idx != $past(bit_idx))); // R7
endmodule

// File: rtl/dtmf_guard_reader.sv
module dtmf_guard_reader #(
  parameter int TICK_DIV   = 3580,
  parameter int PRESENT_MS = 30,
  parameter int ABSENT_MS  = 20,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tone_raw,
  input  logic [CODE_W-1:0] code_in,
  input  logic              rd_clk,
  output logic              early_steer,
  output logic              steer,
  output logic              dout
);
  logic steer_rise;

  assign early_steer = tone_raw;

  dtmf_guard_timer #(
    .TICK_DIV   (TICK_DIV),
    .PRESENT_MS (PRESENT_MS),
    .ABSENT_MS  (ABSENT_MS)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone       (tone_raw),
    .steer      (steer),
    .steer_rise (steer_rise)
  );

  dtmf_readout #(.CODE_W(CODE_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (steer_rise),
    .code_in (code_in),
    .rd_clk  (rd_clk),
    .dout    (dout)
  );

  AST_RISE_ONLY_WITH_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer) |-> $past(early_steer)); // R2
endmodule

// File: tb/dtmf_guard_reader_tb.sv
module dtmf_guard_reader_tb;
  localparam int DIV = 4;
  localparam int PMS = 30;
  localparam int AMS = 20;
  localparam int GP  = PMS * DIV;
  localparam int GA  = AMS * DIV;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tone_raw = 0;
  logic [3:0] code_in = 0;
  logic       rd_clk = 0;
  logic       early_steer, steer, dout;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench reference state
  bit       m_steer = 0;
  int       m_run = 0;
  bit [3:0] m_code = 0;
  bit [3:0] m_sh = 0;
  int       m_idx = 0;
  bit       m_rprev = 0;

  always #2 clk = ~clk;

  dtmf_guard_reader #(.TICK_DIV(DIV), .PRESENT_MS(PMS), .ABSENT_MS(AMS), .CODE_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tone_raw(tone_raw), .code_in(code_in),
    .rd_clk(rd_clk), .early_steer(early_steer), .steer(steer), .dout(dout)
  );

  function automatic int need_edges(input bit cur);
    return cur ? GA : GP;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive at negedge, update reference at the posedge, compare after.
  task automatic cyc(input bit t, input bit [3:0] c, input bit r);
    @(negedge clk);
    tone_raw = t; code_in = c; rd_clk = r;
    #1 chk("R1 early_steer", early_steer, t);
    @(posedge clk);
    #1;
    if (t != m_steer) begin
      m_run++;
      if (m_run == need_edges(m_steer)) begin
        m_steer = !m_steer;
        m_run = 0;
        if (m_steer) m_code = c;
      end
    end else m_run = 0;
    if (r && !m_rprev) begin
      m_sh = (m_idx == 0) ? m_code : (m_sh >> 1);
      m_idx = (m_idx + 1) % 4;
    end
    m_rprev = r;
    chk("R2,R3,R4,R5 steer", steer, m_steer);
    chk("R6,R7 dout", dout, m_sh[0]);
  endtask

  task automatic hold(input bit t, input bit [3:0] c, input int n);
    for (int i = 0; i < n; i++) cyc(t, c, 0);
  endtask

  // Four shift pulses; the value shown after each rise is compared in cyc (R7).
  task automatic readout(input bit t, input bit [3:0] c, input bit [3:0] want, input bit check_want);
    for (int i = 0; i < 4; i++) begin
      cyc(t, c, 1);
      if (check_want) chk("R8 digit bit", dout, want[i]);
      cyc(t, c, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7411);
    // R9 reset state
    repeat (3) begin
      @(negedge clk);
      chk("R9 reset steer", steer, 1'b0);
      chk("R9 reset dout", dout, 1'b0);
    end
    @(negedge clk) rst_n = 1;
    hold(0, 0, 5);

    // R3: burst one edge short of the present guard is rejected
    hold(1, 4'h5, GP - 1);
    hold(0, 4'h5, 3);
    chk("R3 short burst", steer, 1'b0);
    // R2: exact guard length is accepted at the last edge
    hold(1, 4'h9, GP);
    chk("R2 exact present", steer, 1'b1);
    // R5: dropout one edge short of the absent guard is bridged
    hold(0, 4'h9, GA - 1);
    hold(1, 4'h9, 10);
    chk("R5 dropout bridged", steer, 1'b1);
    // R6: code change while steering is high does not reach the readout
    hold(1, 4'h2, 6);
    readout(1, 4'h2, 4'h9, 1);
    // R4: exact absent guard drops steering
    hold(0, 4'h2, GA);
    chk("R4 exact absent", steer, 1'b0);
    readout(0, 4'h2, 4'h9, 1);

    // R8: every code value
    for (int k = 0; k < 16; k++) begin
      hold(1, 4'(k), GP + 2);
      readout(1, 4'(15 - k), 4'(k), 1);
      hold(0, 4'(k), GA + 2);
    end

    // Random mix of bursts, gaps, code changes and readouts
    for (int n = 0; n < 40; n++) begin
      bit [3:0] c0, c1;
      int on_len, off_len;
      c0 = 4'($urandom % 16);
      c1 = 4'($urandom % 16);
      on_len  = $urandom_range(GP + 40, 1);
      off_len = $urandom_range(GA + 30, 1);
      hold(1, c0, on_len / 2);
      hold(1, c1, on_len - on_len / 2);
      if ($urandom % 2 == 1) readout(1, c1, 4'h0, 0);
      hold(0, c1, off_len);
      if ($urandom % 3 == 0) readout(0, c0, 4'h0, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule